// File: doc/BRIEF.md
# Multi-Queue Inter-Processor Mailbox

This block lets several processors pass 32-bit messages to each other through a small set of hardware queues reached over a plain 32-bit register bus. A processor posts a message by writing a queue's message register and collects the oldest pending message by reading that same register. For each queue, two read-only registers report whether it is full and how many messages it holds. A revision word sits at offset zero.

Each processor (user) has its own interrupt status and enable registers. Every queue owns two bits in these registers: a new-message event and a not-full event. Events are posted to the status register of every user, and each user enables only the events it cares about. Status bits clear when written with 1. A parameter selects one of two register maps. The legacy map has a single enable register per user, and software disables an event by read-modify-write. The extended map gives each user separate enable-set and enable-clear registers.

Each queue is controlled by a three-state machine. The states are `Q_EMPTY`, `Q_PART` (holding 1 to DEPTH-1 messages) and `Q_FULL`. Its transitions are:
- `Q_EMPTY`→`Q_PART` on an accepted push.
- `Q_PART`→`Q_PART` on a push that leaves room, or on a pop that leaves at least one message.
- `Q_PART`→`Q_FULL` on a push that takes the count to DEPTH.
- `Q_PART`→`Q_EMPTY` on a pop of the last message.
- `Q_FULL`→`Q_PART` on a pop.

A push while in `Q_FULL` and a pop while in `Q_EMPTY` leave the state unchanged.

Top module: `ipc_mailbox`

## Requirements
- R1: Offset 0x000 reads the revision word. Bits 7:4 hold the major version (default 2), bits 3:0 hold the minor version (default 1), and all other bits are zero. Writes to this offset change nothing.
- R2: A write to offset 0x040+4*m appends the data to queue m. A read of that offset returns and removes the oldest message in queue m. Queues are independent of one another.
- R3: Each queue holds 4 messages. A write to a full queue is dropped, and the queue's count and contents stay unchanged.
- R4: A read of the message register of an empty queue returns 0 and changes no count, no status bit and no other state.
- R5: Offset 0x080+4*m reads 1 when queue m holds 4 messages, and reads 0 otherwise.
- R6: Offset 0x0C0+4*m reads the number of messages pending in queue m, from 0 to 4.
- R7: An accepted push to queue m sets status bit 2*m of every user. A pop that takes queue m out of the full state sets status bit 2*m+1 of every user. A dropped push sets no status bit.
- R8: Writing a 1 to a status bit clears that bit, and writing a 0 leaves it unchanged.
- R9: The interrupt output of user u is high exactly while that user's status ANDed with its enable is nonzero, and this holds in the same cycle as the register change.
- R10: In the legacy layout, user u's status is at 0x100+8*u and its enable is at 0x104+8*u. A write to the enable offset loads the value directly, and a read returns it.
- R11: In the extended layout, user u's status is at 0x104+0x10*u, enable-set is at 0x108+0x10*u and enable-clear is at 0x10C+0x10*u. A 1 in enable-set sets the corresponding bit and a 1 in enable-clear clears it. Both offsets read back the current enable value.
- R12: Offsets that map to no register read 0, and writes to them change nothing. This includes the slot of a queue index at or beyond the queue count, and the slot of a user index at or beyond the user count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read access |
| irq | output | NU (3) | One interrupt line per user |

## Verification
Every queue is swept through the full sequence: filling with five pushes (the fifth overflows), draining with four ordered pops, and one extra pop on the empty queue. This separates the FIFO order, the drop on full and the empty-read rule, and shows whether the count and full flags track each step. Interleaved pushes to two queues show whether queue storage is shared by mistake. The interrupt checks start from cleared status, enable only one queue's event for one user, and then fire events on enabled and disabled bits. This tells the enable path and the status path apart, and it runs in both layouts on two instances. Unmapped probes use out-of-range queue and user slots, which catch a decode that is too wide.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic [1:0] {Q_EMPTY, Q_PART, Q_FULL} qstate_t;

    typedef enum logic [3:0] {
        R_NONE, R_REV, R_MSG, R_FULL, R_CNT, R_STAT, R_EN, R_ENSET, R_ENCLR
    } reg_kind_t;

    typedef struct packed {
        reg_kind_t  kind;
        logic [7:0] idx;
    } reg_sel_t;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int NQ  = 4,
    parameter int NU  = 3,
    parameter int AW  = 10,
    parameter bit EXT = 1'b0
) (
    input  logic [AW-1:0] addr,
    output reg_sel_t      sel
);
    reg_sel_t usel;

    generate
        if (EXT) begin : g_ext
            always_comb begin
                usel = '{kind: R_NONE, idx: 8'd0};
                for (int u = 0; u < NU; u++) begin
                    if (int'(addr) == 'h104 + 16 * u) usel = '{kind: R_STAT,  idx: 8'(u)};
                    if (int'(addr) == 'h108 + 16 * u) usel = '{kind: R_ENSET, idx: 8'(u)};
                    if (int'(addr) == 'h10C + 16 * u) usel = '{kind: R_ENCLR, idx: 8'(u)};
                end
            end
        end else begin : g_legacy
            always_comb begin
                usel = '{kind: R_NONE, idx: 8'd0};
                for (int u = 0; u < NU; u++) begin
                    if (int'(addr) == 'h100 + 8 * u) usel = '{kind: R_STAT, idx: 8'(u)};
                    if (int'(addr) == 'h104 + 8 * u) usel = '{kind: R_EN,   idx: 8'(u)};
                end
            end
        end
    endgenerate

    always_comb begin
        sel = usel;
        if (addr == '0) sel = '{kind: R_REV, idx: 8'd0};
        for (int m = 0; m < NQ; m++) begin
            if (int'(addr) == 'h040 + 4 * m) sel = '{kind: R_MSG,  idx: 8'(m)};
            if (int'(addr) == 'h080 + 4 * m) sel = '{kind: R_FULL, idx: 8'(m)};
            if (int'(addr) == 'h0C0 + 4 * m) sel = '{kind: R_CNT,  idx: 8'(m)};
        end
    end
endmodule

// File: rtl/mbx_queue.sv
module mbx_queue
    import mbx_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 4,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          pushed,
    output logic          unfull
);
    qstate_t       state, nxt;
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] rptr, wptr;
    logic          acc_push, acc_pop;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= Q_EMPTY;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            Q_EMPTY: if (push && !pop) nxt = Q_PART;
            Q_PART: begin
                if (push && !pop && count == CW'(DEPTH - 1))  nxt = Q_FULL;
                else if (pop && !push && count == CW'(1))    nxt = Q_EMPTY;
            end
            Q_FULL:  if (pop && !push) nxt = Q_PART;
            default: nxt = Q_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        acc_push = push && !pop && (state != Q_FULL);
        acc_pop  = pop && !push && (state != Q_EMPTY);
        full     = (state == Q_FULL);
        pushed   = acc_push;
        unfull   = acc_pop && (state == Q_FULL);
        head     = (state == Q_EMPTY) ? '0 : mem[rptr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            wptr  <= '0;
            count <= '0;
        end else begin
            if (acc_push) begin
                wptr  <= (wptr == PW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
                count <= count + 1'b1;
            end
            if (acc_pop) begin
                rptr  <= (rptr == PW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
                count <= count - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (acc_push) mem[wptr] <= wdata;
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));
    // R3
    drop_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL && push && !pop) |=> (count == CW'(DEPTH) && $stable(wptr)));
    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_EMPTY && pop && !push) |=> (count == '0 && $stable(rptr)));
    // R5
    full_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == Q_FULL) == (count == CW'(DEPTH)));
endmodule

// File: rtl/mbx_user_irq.sv
module mbx_user_irq #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] set_ev,
    input  logic          st_w1c,
    input  logic          en_wr,
    input  logic          en_set,
    input  logic          en_clr,
    input  logic [NB-1:0] wdata,
    output logic [NB-1:0] status,
    output logic [NB-1:0] enable,
    output logic          irq
);
    logic [NB-1:0] clr_mask;

    always_comb clr_mask = st_w1c ? wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status <= '0;
            enable <= '0;
        end else begin
            status <= (status & ~clr_mask) | set_ev;
            if (en_wr)       enable <= wdata;
            else if (en_set) enable <= enable | wdata;
            else if (en_clr) enable <= enable & ~wdata;
        end
    end

    always_comb irq = |(status & enable);

    // R7
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((status & $past(set_ev)) == $past(set_ev)));
    // R8
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_w1c && set_ev == '0) |=> ((status & $past(wdata)) == '0));
    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|set_ev) || $past(en_wr || en_set)));
endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int         NQ        = 4,
    parameter int         NU        = 3,
    parameter int         DEPTH     = 4,
    parameter int         AW        = 10,
    parameter bit         EXT       = 1'b0,
    parameter logic [3:0] REV_MAJOR = 4'h2,
    parameter logic [3:0] REV_MINOR = 4'h1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_sel,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [31:0]   bus_wdata,
    output logic [31:0]   bus_rdata,
    output logic [NU-1:0] irq
);
    localparam int NB = 2 * NQ;
    localparam int CW = $clog2(DEPTH + 1);

    reg_sel_t      rsel;
    logic          do_wr, do_rd;
    logic [31:0]   qhead [NQ];
    logic [CW-1:0] qcnt  [NQ];
    logic [NQ-1:0] qfull, qpushed, qunfull;
    logic [NB-1:0] events;
    logic [NB-1:0] ust [NU];
    logic [NB-1:0] uen [NU];

    mbx_decode #(.NQ(NQ), .NU(NU), .AW(AW), .EXT(EXT)) dec_i (
        .addr(bus_addr), .sel(rsel)
    );

    always_comb begin
        do_wr = bus_sel && bus_wr;
        do_rd = bus_sel && !bus_wr;
    end

    generate
        for (genvar m = 0; m < NQ; m++) begin : g_q
            mbx_queue #(.DW(32), .DEPTH(DEPTH)) q_i (
                .clk(clk), .rst_n(rst_n),
                .push(do_wr && rsel.kind == R_MSG && rsel.idx == 8'(m)),
                .pop (do_rd && rsel.kind == R_MSG && rsel.idx == 8'(m)),
                .wdata(bus_wdata),
                .head(qhead[m]), .count(qcnt[m]), .full(qfull[m]),
                .pushed(qpushed[m]), .unfull(qunfull[m])
            );
            assign events[2*m]   = qpushed[m];
            assign events[2*m+1] = qunfull[m];
        end
        for (genvar u = 0; u < NU; u++) begin : g_u
            mbx_user_irq #(.NB(NB)) u_i (
                .clk(clk), .rst_n(rst_n), .set_ev(events),
                .st_w1c(do_wr && rsel.kind == R_STAT  && rsel.idx == 8'(u)),
                .en_wr (do_wr && rsel.kind == R_EN    && rsel.idx == 8'(u)),
                .en_set(do_wr && rsel.kind == R_ENSET && rsel.idx == 8'(u)),
                .en_clr(do_wr && rsel.kind == R_ENCLR && rsel.idx == 8'(u)),
                .wdata(bus_wdata[NB-1:0]),
                .status(ust[u]), .enable(uen[u]), .irq(irq[u])
            );
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        if (rsel.kind == R_REV) bus_rdata = {24'd0, REV_MAJOR, REV_MINOR};
        for (int m = 0; m < NQ; m++) begin
            if (rsel.idx == 8'(m)) begin
                if (rsel.kind == R_MSG)  bus_rdata = qhead[m];
                if (rsel.kind == R_FULL) bus_rdata = {31'd0, qfull[m]};
                if (rsel.kind == R_CNT)  bus_rdata = 32'(qcnt[m]);
            end
        end
        for (int u = 0; u < NU; u++) begin
            if (rsel.idx == 8'(u)) begin
                if (rsel.kind == R_STAT) bus_rdata = 32'(ust[u]);
                if (rsel.kind == R_EN || rsel.kind == R_ENSET || rsel.kind == R_ENCLR)
                    bus_rdata = 32'(uen[u]);
            end
        end
    end

    // R2
    pop_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && rsel.kind == R_MSG && qcnt[0] != '0 && rsel.idx == 8'd0)
            |=> (qcnt[0] == $past(qcnt[0]) - 1'b1));
    // R7
    unfull_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        qunfull[0] |=> !qfull[0]);
endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_l = 1'b0, sel_x = 1'b0, wr = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_l, rd_x;
    logic [2:0]  irq_l, irq_x;
    int          total = 0, bad = 0;
    logic [31:0] v;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ipc_mailbox #(.EXT(1'b0)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_l), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_l), .irq(irq_l)
    );
    ipc_mailbox #(.EXT(1'b1)) dut_x (
        .clk(clk), .rst_n(rst_n), .bus_sel(sel_x), .bus_wr(wr), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rd_x), .irq(irq_x)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input bit x, input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        sel_l = !x; sel_x = x; wr = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        sel_l = 1'b0; sel_x = 1'b0; wr = 1'b0;
    endtask

    task automatic rd_reg(input bit x, input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        sel_l = !x; sel_x = x; wr = 1'b0; addr = a;
        #1 d = x ? rd_x : rd_l;
        @(posedge clk); #1;
        sel_l = 1'b0; sel_x = 1'b0;
    endtask

    task automatic clear_all_status();
        for (int u = 0; u < 3; u++) begin
            wr_reg(1'b0, 10'(32'h100 + 8 * u), 32'hFFFF_FFFF);
            wr_reg(1'b1, 10'(32'h104 + 16 * u), 32'hFFFF_FFFF);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // reset state
        #1 check("R9 reset irq", 32'(irq_l), 32'd0);
        rd_reg(1'b0, 10'h0C4, v); check("R6 reset count", v, 32'd0);

        // R1 revision, write ignored
        rd_reg(1'b0, 10'h000, v); check("R1 rev", v, 32'h21);
        wr_reg(1'b0, 10'h000, 32'hFFFF_FFFF);
        rd_reg(1'b0, 10'h000, v); check("R1 rev after write", v, 32'h21);
        rd_reg(1'b1, 10'h000, v); check("R1 rev ext", v, 32'h21);

        // R12 unmapped
        rd_reg(1'b0, 10'h050, v); check("R12 queue slot 4", v, 32'd0);
        rd_reg(1'b0, 10'h3FC, v); check("R12 high offset", v, 32'd0);
        rd_reg(1'b0, 10'h118, v); check("R12 legacy user 3", v, 32'd0);
        rd_reg(1'b1, 10'h100, v); check("R12 ext 0x100", v, 32'd0);
        wr_reg(1'b0, 10'h050, 32'h1234);
        wr_reg(1'b0, 10'h118, 32'hFF);
        for (int m = 0; m < 4; m++) begin
            rd_reg(1'b0, 10'(32'h0C0 + 4 * m), v); check("R12 counts unchanged", v, 32'd0);
        end
        rd_reg(1'b0, 10'h100, v); check("R12 no status", v, 32'd0);

        // queue sweep on legacy instance
        for (int m = 0; m < 4; m++) begin
            clear_all_status();
            for (int k = 0; k < 5; k++) begin
                wr_reg(1'b0, 10'(32'h040 + 4 * m), 32'hA000_0000 | 32'(m << 8) | 32'(k));
                rd_reg(1'b0, 10'(32'h0C0 + 4 * m), v);
                check("R6 R3 count", v, 32'((k + 1 > 4) ? 4 : k + 1));
                rd_reg(1'b0, 10'(32'h080 + 4 * m), v);
                check("R5 full flag", v, 32'(k >= 3));
            end
            rd_reg(1'b0, 10'h100, v); check("R7 newmsg bit user0", v, 32'(1 << (2 * m)));
            for (int k = 0; k < 4; k++) begin
                rd_reg(1'b0, 10'(32'h040 + 4 * m), v);
                check("R2 R3 fifo order", v, 32'hA000_0000 | 32'(m << 8) | 32'(k));
            end
            rd_reg(1'b0, 10'h110, v); check("R7 notfull bit user2", v, 32'(3 << (2 * m)));
            rd_reg(1'b0, 10'(32'h040 + 4 * m), v); check("R4 empty read", v, 32'd0);
            rd_reg(1'b0, 10'(32'h0C0 + 4 * m), v); check("R4 count stays 0", v, 32'd0);
            rd_reg(1'b0, 10'h108, v); check("R4 no event", v, 32'(3 << (2 * m)));
            wr_reg(1'b0, 10'h108, 32'd0);
            rd_reg(1'b0, 10'h108, v); check("R8 write 0 keeps", v, 32'(3 << (2 * m)));
            wr_reg(1'b0, 10'h108, 32'(1 << (2 * m)));
            rd_reg(1'b0, 10'h108, v); check("R8 w1c one bit", v, 32'(2 << (2 * m)));
        end

        // R2 independence
        wr_reg(1'b0, 10'h040, 32'h11);
        wr_reg(1'b0, 10'h044, 32'h22);
        wr_reg(1'b0, 10'h040, 32'h33);
        rd_reg(1'b0, 10'h044, v); check("R2 independent q1", v, 32'h22);
        rd_reg(1'b0, 10'h040, v); check("R2 independent q0a", v, 32'h11);
        rd_reg(1'b0, 10'h040, v); check("R2 independent q0b", v, 32'h33);

        // R9 R10 legacy interrupts
        clear_all_status();
        #1 check("R9 irq cleared", 32'(irq_l), 32'd0);
        wr_reg(1'b0, 10'h10C, 32'h4);
        rd_reg(1'b0, 10'h10C, v); check("R10 enable readback", v, 32'h4);
        wr_reg(1'b0, 10'h040, 32'h5);
        check("R9 disabled event", 32'(irq_l), 32'd0);
        wr_reg(1'b0, 10'h044, 32'h6);
        check("R9 R10 enabled event", 32'(irq_l), 32'b010);
        wr_reg(1'b0, 10'h108, 32'h4);
        check("R9 R8 w1c drops irq", 32'(irq_l), 32'd0);
        wr_reg(1'b0, 10'h044, 32'h7);
        check("R9 refire", 32'(irq_l), 32'b010);
        wr_reg(1'b0, 10'h10C, 32'h0);
        check("R10 rmw disable", 32'(irq_l), 32'd0);

        // R11 extended layout
        clear_all_status();
        wr_reg(1'b1, 10'h128, 32'h3);
        rd_reg(1'b1, 10'h128, v); check("R11 enable set", v, 32'h3);
        wr_reg(1'b1, 10'h12C, 32'h1);
        rd_reg(1'b1, 10'h12C, v); check("R11 enable clear", v, 32'h2);
        wr_reg(1'b1, 10'h040, 32'h9);
        check("R11 R9 masked", 32'(irq_x), 32'd0);
        rd_reg(1'b1, 10'h104, v); check("R11 status user0", v, 32'h1);
        wr_reg(1'b1, 10'h128, 32'h1);
        check("R11 R9 set enables", 32'(irq_x), 32'b100);
        wr_reg(1'b1, 10'h124, 32'h1);
        check("R11 R8 w1c", 32'(irq_x), 32'd0);
        check("R10 legacy untouched", 32'(irq_l), 32'd0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule